// File: doc/BRIEF.md
# PC Card Access Strobe Sequencer

This block turns one host access request into the strobe waveform a PC card expects. When it takes a request, it drives the card address, including the two upper address bits chosen by the address space. It then lowers chip-enable for a programmable setup interval and pulses output-enable (read) or write-enable (write) for a programmable width. Chip-enable is held for one or two further clocks, and the block signals completion with a single-cycle pulse. Read data is sampled from the card on the final clock of the strobe pulse.

All timing and mode choices come from a 16-bit per-card control word, and the block samples it at the start of each access. The control word also selects byte-lane reversal, automatic address stepping between accesses and a power-down gate. While power-down is set, the block refuses requests and holds all strobes inactive. Strobes are active low.

Top module: `pccard_strobe_gen`

## Requirements
- R1: After reset, `ce_n`, `oe_n` and `we_n` are 1 and `done`, `busy` and `refused` are 0.
- R2: An accepted request holds `ce_n` low with both `oe_n` and `we_n` high for n+1 clocks before the strobe, where n is control bits [6:4].
- R3: The strobe lasts n+2 clocks, where n is control bits [9:7]. `oe_n` is used for a read (`req_write`=0) and `we_n` for a write. The two strobes are never low together, and neither is low while `ce_n` is high.
- R4: After the strobe ends, `ce_n` stays low for 1 clock when control bit 10 is 0 and for 2 clocks when it is 1.
- R5: `done` is high for exactly one clock, right after the hold interval, with `ce_n` high.
- R6: `rdata` carries the card data sampled on the last strobe clock and is valid while `done` is high.
- R7: `card_addr[25:24]` equals control bits [1:0] for `req_space`=01 (attribute), control bits [3:2] for `req_space`=10 (I/O), and 00 for any other code.
- R8: When exactly one of control bits 11 and 12 is set, the two bytes are exchanged on both `card_wdata` and `rdata`. When both are set or neither is, the bytes pass straight through.
- R9: `req_reuse`=0 loads `req_addr`, and `req_reuse`=1 reuses the held address. After each completed access the held address grows by 2 if control bit 14 is 0 and is unchanged if it is 1.
- R10: While control bit 15 is set, a request raises `refused` for one clock and starts no access. Setting the bit during an access ends it on the next clock with all strobes high and no `done`.
- R11: `busy` is high from the clock after acceptance through the `done` clock and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_word | input | 16 | Per-card control word |
| req | input | 1 | Access request, sampled while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_space | input | 2 | 00 common, 01 attribute, 10 I/O |
| req_reuse | input | 1 | 1 = use the held address instead of req_addr |
| req_addr | input | 24 | Lower card address |
| req_wdata | input | 16 | Host write data |
| card_rdata | input | 16 | Data returned by the card |
| card_addr | output | 26 | Card address including upper bits |
| card_wdata | output | 16 | Write data after lane ordering |
| ce_n | output | 1 | Chip enable, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |
| rdata | output | 16 | Captured read data after lane ordering |
| done | output | 1 | One-clock completion pulse |
| busy | output | 1 | Access in progress |
| refused | output | 1 | Request rejected due to power-down |

## Verification
A wrong phase counter or a bad reload shows up within one access as a setup, strobe or hold run that is one clock off at `ce_n`, `oe_n` and `we_n`. A missing `done`, or a double one, is visible within a clock of the hold ending. A wrong capture instant or wrong lane choice shows up on `rdata` in the `done` cycle. An address pointer that steps badly only shows up on the next access that reuses the held address, so runs of back-to-back reuse accesses are needed to expose it.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int CTRL_W      = 16;
  localparam int TFIELD_W    = 3;
  localparam int UPPER_W     = 2;
  // Control word bit positions (decoded by the sequencer and address path)
  localparam int ATTR_LSB    = 0;
  localparam int IO_LSB      = 2;
  localparam int SETUP_LSB   = 4;
  localparam int WIDTH_LSB   = 7;
  localparam int HOLD_BIT    = 10;
  localparam int HOST_LE_BIT = 11;
  localparam int CARD_BE_BIT = 12;
  localparam int RDAHEAD_BIT = 13;
  localparam int NOINC_BIT   = 14;
  localparam int PWRDN_BIT   = 15;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD, PH_DONE
  } phase_t;

  localparam logic [1:0] SP_ATTR = 2'b01;
  localparam logic [1:0] SP_IO   = 2'b10;

  // Counter reload values: a phase lasts (load + 1) clocks
  function automatic logic [TFIELD_W:0] setup_load(input logic [TFIELD_W-1:0] n);
    return {1'b0, n};
  endfunction

  function automatic logic [TFIELD_W:0] strobe_load(input logic [TFIELD_W-1:0] n);
    return {1'b0, n} + 1'b1;
  endfunction

  function automatic logic [TFIELD_W:0] hold_load(input logic long_hold);
    return long_hold ? 1 : 0;
  endfunction

  function automatic logic [UPPER_W-1:0] upper_bits(input logic [1:0] space,
                                                    input logic [UPPER_W-1:0] attr_hi,
                                                    input logic [UPPER_W-1:0] io_hi);
    case (space)
      SP_ATTR: return attr_hi;
      SP_IO:   return io_hi;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/pcs_lane_swap.sv
module pcs_lane_swap #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] din,
  input  logic          en,
  output logic [DW-1:0] dout
);
  localparam int NB = DW / 8;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign dout[b*8 +: 8] = en ? din[(NB-1-b)*8 +: 8] : din[b*8 +: 8];
  end
endmodule

// File: rtl/pcs_addr_unit.sv
module pcs_addr_unit #(
  parameter int AW = 24,
  parameter int UW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          reuse,
  input  logic [AW-1:0] req_addr,
  input  logic [UW-1:0] upper_in,
  input  logic          no_inc,
  input  logic          done,
  output logic [UW+AW-1:0] card_addr
);
  localparam logic [AW-1:0] STEP = AW'(2);

  logic [AW-1:0] ptr_q;
  logic [UW-1:0] upper_q;
  logic          no_inc_q;
  logic          step_evt;

  assign step_evt = done && !no_inc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      upper_q  <= '0;
      no_inc_q <= 1'b0;
    end else if (start) begin
      if (!reuse) ptr_q <= req_addr;
      upper_q  <= upper_in;
      no_inc_q <= no_inc;
    end else if (step_evt) begin
      ptr_q <= ptr_q + STEP;
    end
  end

  assign card_addr = {upper_q, ptr_q};

  // R9: held address advances by two after a completed access
  a_r9_step: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> ptr_q == $past(ptr_q) + STEP);
  // R9: with stepping disabled the address holds across completion
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && no_inc_q) |=> $stable(ptr_q));
endmodule

// File: rtl/pcs_phase_seq.sv
module pcs_phase_seq
  import pcs_pkg::*;
#(
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          pwrdn,
  input  logic          is_write,
  input  logic [TW-1:0] setup_n,
  input  logic [TW-1:0] width_n,
  input  logic          long_hold,
  output phase_t        phase,
  output logic          ce_n,
  output logic          oe_n,
  output logic          we_n,
  output logic          cap_evt,
  output logic          done
);
  localparam int CW = TW + 1;

  phase_t        phase_q;
  logic [CW-1:0] cnt_q;
  logic [TW-1:0] width_q;
  logic          hold_q;
  logic          wr_q;
  logic          cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      width_q <= '0;
      hold_q  <= 1'b0;
      wr_q    <= 1'b0;
    end else if (pwrdn) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (start) begin
          phase_q <= PH_SETUP;
          cnt_q   <= setup_load(setup_n);
          width_q <= width_n;
          hold_q  <= long_hold;
          wr_q    <= is_write;
        end
        PH_SETUP: if (cnt_zero) begin
          phase_q <= PH_STROBE;
          cnt_q   <= strobe_load(width_q);
        end else cnt_q <= cnt_q - 1'b1;
        PH_STROBE: if (cnt_zero) begin
          phase_q <= PH_HOLD;
          cnt_q   <= hold_load(hold_q);
        end else cnt_q <= cnt_q - 1'b1;
        PH_HOLD: if (cnt_zero) phase_q <= PH_DONE;
                 else cnt_q <= cnt_q - 1'b1;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase   = phase_q;
  assign ce_n    = !(phase_q == PH_SETUP || phase_q == PH_STROBE || phase_q == PH_HOLD);
  assign oe_n    = !(phase_q == PH_STROBE && !wr_q);
  assign we_n    = !(phase_q == PH_STROBE && wr_q);
  assign cap_evt = (phase_q == PH_STROBE) && cnt_zero && !wr_q;
  assign done    = (phase_q == PH_DONE);

  // R3: never both strobes at once
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));
  // R3: a strobe only inside a chip-enable window
  a_r3_strobe_in_ce: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n || !we_n) |-> !ce_n);
  // R4: chip enable outlives the strobe by at least one clock
  a_r4_hold_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwrdn && !$past(pwrdn) && $past(phase_q) == PH_STROBE && phase_q != PH_STROBE) |-> !ce_n);
  // R5: completion is a single-clock pulse with chip enable released
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r5_done_ce_high: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ce_n);
  // R10: power-down forces all strobes inactive on the next clock
  a_r10_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    pwrdn |=> (ce_n && oe_n && we_n));
endmodule

// File: rtl/pccard_strobe_gen.sv
module pccard_strobe_gen
  import pcs_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic              req,
  input  logic              req_write,
  input  logic [1:0]        req_space,
  input  logic              req_reuse,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [DW-1:0]     card_rdata,
  output logic [UPPER_W+AW-1:0] card_addr,
  output logic [DW-1:0]     card_wdata,
  output logic              ce_n,
  output logic              oe_n,
  output logic              we_n,
  output logic [DW-1:0]     rdata,
  output logic              done,
  output logic              busy,
  output logic              refused
);
  logic                ctrl_unused;
  logic                pwrdn;
  logic                swap_sel;
  logic                accept;
  logic                cap_evt;
  logic                swap_q;
  logic                refused_q;
  logic [UPPER_W-1:0]  upper_sel;
  logic [DW-1:0]       wdata_sw;
  logic [DW-1:0]       rdata_sw;
  logic [DW-1:0]       wdata_q;
  logic [DW-1:0]       rdata_q;
  phase_t              phase;

  assign ctrl_unused = ctrl_word[RDAHEAD_BIT];
  assign pwrdn    = ctrl_word[PWRDN_BIT];
  assign swap_sel = ctrl_word[HOST_LE_BIT] ^ ctrl_word[CARD_BE_BIT];
  assign accept   = (phase == PH_IDLE) && req && !pwrdn;
  assign upper_sel = upper_bits(req_space,
                                ctrl_word[ATTR_LSB +: UPPER_W],
                                ctrl_word[IO_LSB +: UPPER_W]);

  pcs_phase_seq #(.TW(TFIELD_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .pwrdn     (pwrdn),
    .is_write  (req_write),
    .setup_n   (ctrl_word[SETUP_LSB +: TFIELD_W]),
    .width_n   (ctrl_word[WIDTH_LSB +: TFIELD_W]),
    .long_hold (ctrl_word[HOLD_BIT]),
    .phase     (phase),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .cap_evt   (cap_evt),
    .done      (done)
  );

  pcs_addr_unit #(.AW(AW), .UW(UPPER_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .reuse     (req_reuse),
    .req_addr  (req_addr),
    .upper_in  (upper_sel),
    .no_inc    (ctrl_word[NOINC_BIT]),
    .done      (done),
    .card_addr (card_addr)
  );

  pcs_lane_swap #(.DW(DW)) u_wswap (.din(req_wdata),  .en(swap_sel), .dout(wdata_sw));
  pcs_lane_swap #(.DW(DW)) u_rswap (.din(card_rdata), .en(swap_q),   .dout(rdata_sw));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swap_q    <= 1'b0;
      wdata_q   <= '0;
      rdata_q   <= '0;
      refused_q <= 1'b0;
    end else begin
      refused_q <= (phase == PH_IDLE) && req && pwrdn;
      if (accept) begin
        swap_q  <= swap_sel;
        wdata_q <= wdata_sw;
      end
      if (cap_evt) rdata_q <= rdata_sw;
    end
  end

  assign card_wdata = wdata_q;
  assign rdata      = rdata_q;
  assign busy       = (phase != PH_IDLE);
  assign refused    = refused_q;

  // R10: a refused request never starts an access
  a_r10_refuse_idle: assert property (@(posedge clk) disable iff (!rst_n)
    refused |-> !busy);
  // R11: busy covers every active strobe window
  a_r11_busy_cover: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n || done) |-> busy);
endmodule

// File: tb/pccard_strobe_gen_bench.sv
module pccard_strobe_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ctrl_word = '0;
  logic        req = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_space = 2'b00;
  logic        req_reuse = 1'b0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [15:0] card_rdata = '0;
  logic [25:0] card_addr;
  logic [15:0] card_wdata;
  logic        ce_n, oe_n, we_n;
  logic [15:0] rdata;
  logic        done, busy, refused;

  int checks = 0;
  int fails  = 0;

  int          m_setup, m_strobe, m_hold;
  bit          m_done, m_oe, m_we, m_busy_ok;
  logic [25:0] m_addr;
  logic [15:0] m_wdata, m_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  pccard_strobe_gen u_pccard_strobe_gen (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .req(req),
    .req_write(req_write), .req_space(req_space), .req_reuse(req_reuse),
    .req_addr(req_addr), .req_wdata(req_wdata), .card_rdata(card_rdata),
    .card_addr(card_addr), .card_wdata(card_wdata), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .rdata(rdata), .done(done), .busy(busy), .refused(refused)
  );

  function automatic logic [15:0] mk_ctrl(input logic [1:0] attr, input logic [1:0] io,
      input logic [2:0] s, input logic [2:0] w, input logic h, input logic le,
      input logic be, input logic noinc, input logic pd);
    return {pd, noinc, 1'b0, be, le, h, w, s, io, attr};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Drives one request and measures the resulting waveform at negedges
  task automatic run_access(input logic [15:0] c, input logic wr, input logic [1:0] sp,
      input logic reuse, input logic [23:0] a, input logic [15:0] wd, input logic [15:0] rd);
    bit seen_strobe;
    seen_strobe = 0;
    m_setup = 0; m_strobe = 0; m_hold = 0;
    m_done = 0; m_oe = 0; m_we = 0; m_busy_ok = 1;
    m_addr = '0; m_wdata = '0; m_rdata = '0;
    @(negedge clk);
    ctrl_word = c; req_write = wr; req_space = sp; req_reuse = reuse;
    req_addr = a; req_wdata = wd; card_rdata = rd; req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (!busy) m_busy_ok = 0;
      if (done) begin
        m_done = 1; m_rdata = rdata;
        break;
      end
      if (!oe_n || !we_n) begin
        seen_strobe = 1; m_strobe++;
        if (!oe_n) m_oe = 1;
        if (!we_n) m_we = 1;
        m_addr = card_addr; m_wdata = card_wdata;
      end else if (!ce_n) begin
        if (seen_strobe) m_hold++; else m_setup++;
      end
      @(negedge clk);
    end
    @(negedge clk);
    check("R5 done one clock", {31'b0, done}, 32'd0);
    check("R11 busy low after done", {31'b0, busy}, 32'd0);
  endtask

  task automatic t_reset;
    check("R1 ce_n", {31'b0, ce_n}, 1);
    check("R1 oe_n", {31'b0, oe_n}, 1);
    check("R1 we_n", {31'b0, we_n}, 1);
    check("R1 done/busy/refused", {29'b0, done, busy, refused}, 0);
  endtask

  task automatic t_fast_read;
    run_access(mk_ctrl(2'b11, 2'b11, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0),
               1'b0, 2'b00, 1'b0, 24'h001234, 16'h0, 16'hA55A);
    check("R2 setup min", m_setup, 1);
    check("R3 strobe min", m_strobe, 2);
    check("R3 read uses oe", {30'b0, m_oe, m_we}, 32'b10);
    check("R4 short hold", m_hold, 1);
    check("R5 done seen", {31'b0, m_done}, 1);
    check("R6 read data", m_rdata, 16'hA55A);
    check("R7 common upper", m_addr, 26'h0001234);
    check("R11 busy throughout", {31'b0, m_busy_ok}, 1);
  endtask

  task automatic t_attr_write_swap;
    run_access(mk_ctrl(2'b10, 2'b01, 3'd5, 3'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0),
               1'b1, 2'b01, 1'b0, 24'h00ABCD, 16'h1234, 16'h0);
    check("R2 setup 5", m_setup, 6);
    check("R3 strobe 3", m_strobe, 5);
    check("R3 write uses we", {30'b0, m_oe, m_we}, 32'b01);
    check("R4 long hold", m_hold, 2);
    check("R7 attribute upper", m_addr, {2'b10, 24'h00ABCD});
    check("R8 write swap", m_wdata, 16'h3412);
  endtask

  task automatic t_io_read_noswap;
    run_access(mk_ctrl(2'b10, 2'b01, 3'd7, 3'd7, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0),
               1'b0, 2'b10, 1'b0, 24'h000020, 16'h0, 16'hBEEF);
    check("R2 setup 7", m_setup, 8);
    check("R3 strobe 7", m_strobe, 9);
    check("R7 io upper", m_addr, {2'b01, 24'h000020});
    check("R8 both bits no swap", m_rdata, 16'hBEEF);
    run_access(mk_ctrl(2'b00, 2'b00, 3'd1, 3'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0),
               1'b0, 2'b00, 1'b0, 24'h000030, 16'h0, 16'hC0DE);
    check("R8 read swap", m_rdata, 16'hDEC0);
  endtask

  task automatic t_autoinc;
    logic [15:0] c;
    c = mk_ctrl(2'b00, 2'b00, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    run_access(c, 1'b0, 2'b00, 1'b0, 24'h000100, 16'h0, 16'h0);
    check("R9 load address", m_addr, 26'h0000100);
    run_access(c, 1'b0, 2'b00, 1'b1, 24'h000F00, 16'h0, 16'h0);
    check("R9 step 1", m_addr, 26'h0000102);
    run_access(c, 1'b1, 2'b00, 1'b1, 24'h000F00, 16'h0, 16'h0);
    check("R9 step 2", m_addr, 26'h0000104);
    c[14] = 1'b1;
    run_access(c, 1'b0, 2'b00, 1'b1, 24'h000F00, 16'h0, 16'h0);
    check("R9 step 3 then disabled", m_addr, 26'h0000106);
    run_access(c, 1'b0, 2'b00, 1'b1, 24'h000F00, 16'h0, 16'h0);
    check("R9 no increment", m_addr, 26'h0000106);
  endtask

  task automatic t_powerdown;
    bit quiet;
    quiet = 1;
    @(negedge clk);
    ctrl_word = mk_ctrl(2'b00, 2'b00, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    req_reuse = 1'b0; req = 1'b1;
    @(negedge clk);
    check("R10 refused pulse", {31'b0, refused}, 1);
    req = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!ce_n || !oe_n || !we_n || done || busy || refused) quiet = 0;
    end
    check("R10 quiet while powered down", {31'b0, quiet}, 1);
    // abort mid-strobe
    @(negedge clk);
    ctrl_word = mk_ctrl(2'b00, 2'b00, 3'd2, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    req_write = 1'b0; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    for (int i = 0; i < 10; i++) begin
      if (!oe_n) break;
      @(negedge clk);
    end
    check("R3 strobe reached before abort", {31'b0, oe_n}, 0);
    ctrl_word[15] = 1'b1;
    @(negedge clk);
    check("R10 abort releases strobes", {29'b0, ce_n, oe_n, we_n}, 32'b111);
    quiet = 1;
    for (int i = 0; i < 12; i++) begin
      if (done || busy) quiet = 0;
      @(negedge clk);
    end
    check("R10 no done after abort", {31'b0, quiet}, 1);
    ctrl_word[15] = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_fast_read();
    t_attr_write_swap();
    t_io_read_noswap();
    t_autoinc();
    t_powerdown();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule